// File: doc/BRIEF.md
# GPIO Interrupt Source Selector

This block routes a wide pool of general-purpose input lines onto a fixed set of thirty-two interrupt slots. Each slot owns one byte of routing state: a source number that picks any line of the pool and an enable flag. It also has a two-bit sense field that chooses rising-edge, falling-edge, high-level or low-level detection. When the chosen condition is seen on an enabled slot, that slot's status bit is latched. The slot then holds its active-high request line to the parent interrupt controller until software clears the bit.

The pool inputs pass through a two-flop synchronizer before use. Each slot runs a small state machine with three states. `SLOT_OFF` means the slot is disabled. `SLOT_PRIME` lasts one cycle, during which the slot reloads its history from the selected line without detecting anything. `SLOT_LIVE` means detection is active. The transitions are:
- OFF to PRIME when the enable flag is set.
- PRIME to LIVE if the slot is still enabled after the priming cycle.
- PRIME to OFF if the enable flag is cleared during priming.
- LIVE to PRIME when the source number is rewritten while the slot is enabled.
- LIVE to OFF when the enable flag is cleared.

Software reaches all state through a plain synchronous port made of address, write data, write enable and read enable. Read data is combinational.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads 0: all slots are disabled with rising-edge sense, every status bit is clear, and every request is low.
- R2: Slot n has a routing byte at address 0x30 + 4*(n/4), in bits [8*(n%4)+7 : 8*(n%4)]. Bit 7 of that byte is the enable flag and bits 6:0 are the source line number. The whole byte reads back as written.
- R3: The sense fields of slots 0-15 are at address 0x24 and those of slots 16-31 are at 0x28. Each slot's field is bits [2m+1:2m], where m is the slot index modulo 16. The fields read back as written. The codes are 0 for rising edge, 1 for falling edge, 2 for high level and 3 for low level.
- R4: In rising mode, a 0-to-1 change on the selected line shows on the slot's request after exactly three clock edges. A 1-to-0 change sets nothing.
- R5: In falling mode, a 1-to-0 change on the selected line shows on the request after exactly three clock edges. A 0-to-1 change sets nothing.
- R6: In high-level or low-level mode, the status bit sets three clock edges after the line enters the active level.
- R7: The status register at 0x20 holds bit n for slot n. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R8: In a level mode, clearing the status bit while the level still holds drops the request for exactly one cycle, and it reasserts on the next cycle.
- R9: A disabled slot sets no status bit. Its request is the AND of its status bit and its enable flag, so a bit latched earlier is masked while the slot is disabled and shows again when the slot is re-enabled.
- R10: Enabling a slot, or changing its source while it is enabled, reloads the slot's history from the current line value. No stale history produces an event, and detection resumes afterwards.
- R11: A source number at or above the number of connected lines reads as a constant 0 input.
- R12: Addresses outside the listed registers read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | NUM_GPIO | Asynchronous input line pool |
| reg_addr | input | 8 | Register byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, acts on the rising clock edge |
| reg_re | input | 1 | Read strobe; read data is 0 when low |
| reg_rdata | output | 32 | Combinational read data |
| irq_out | output | NUM_SLOTS | Per-slot active-high request level |

## Verification
The assertions assume the following about the block's inputs:
- Register writes are single-cycle strobes with a stable address and data.
- Any line change has passed through the synchronizer before a slot judges it, so each judgement uses values that are already registered.
- A source rewrite is seen by the slot in the same cycle as the new routing byte.

The stimulus keeps within these assumptions in four ways:
- It changes lines and strobes only at falling clock edges.
- It enables only one slot at a time.
- It disables a slot before clearing its status.
- It waits several cycles after each line change so the synchronizer has settled before the next step.

// File: rtl/gir_pkg.sv
package gir_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] ADDR_STATUS  = 8'h20;
    localparam logic [REG_AW-1:0] ADDR_SENSE_LO = 8'h24;
    localparam logic [REG_AW-1:0] ADDR_SENSE_HI = 8'h28;
    localparam logic [REG_AW-1:0] ADDR_ROUTE0  = 8'h30;

    typedef enum logic [1:0] {
        SENSE_RISE = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_HIGH = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_t;

    typedef enum logic [1:0] {
        SLOT_OFF   = 2'd0,
        SLOT_PRIME = 2'd1,
        SLOT_LIVE  = 2'd2
    } slot_state_t;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gir_regfile.sv
module gir_regfile
    import gir_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SEL_W     = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [REG_AW-1:0]        addr,
    input  logic [REG_DW-1:0]        wdata,
    input  logic                     we,
    input  logic                     re,
    output logic [REG_DW-1:0]        rdata,
    input  logic [NUM_SLOTS-1:0]     status,
    output logic [NUM_SLOTS-1:0]     en,
    output logic [NUM_SLOTS*SEL_W-1:0] src_flat,
    output logic [2*NUM_SLOTS-1:0]   sense_flat
);
    localparam int SLOTS_PER_ROUTE = 4;
    localparam int SLOTS_PER_SENSE = 16;
    localparam int ROUTE_REGS      = NUM_SLOTS / SLOTS_PER_ROUTE;

    logic [7:0] route_q [NUM_SLOTS];
    logic [1:0] sense_q [NUM_SLOTS];

    function automatic logic [REG_AW-1:0] route_addr(input int slot);
        return ADDR_ROUTE0 + REG_AW'(4 * (slot / SLOTS_PER_ROUTE));
    endfunction

    function automatic logic [REG_AW-1:0] sense_addr(input int slot);
        return (slot < SLOTS_PER_SENSE) ? ADDR_SENSE_LO : ADDR_SENSE_HI;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                route_q[i] <= '0;
                sense_q[i] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (addr == route_addr(i))
                    route_q[i] <= wdata[8*(i % SLOTS_PER_ROUTE) +: 8];
                if (addr == sense_addr(i))
                    sense_q[i] <= wdata[2*(i % SLOTS_PER_SENSE) +: 2];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            if (addr == ADDR_STATUS)
                rdata[NUM_SLOTS-1:0] = status;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (addr == route_addr(i))
                    rdata[8*(i % SLOTS_PER_ROUTE) +: 8] = route_q[i];
                if (addr == sense_addr(i))
                    rdata[2*(i % SLOTS_PER_SENSE) +: 2] = sense_q[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_out
        assign en[g]                     = route_q[g][7];
        assign src_flat[g*SEL_W +: SEL_W] = route_q[g][SEL_W-1:0];
        assign sense_flat[2*g +: 2]      = sense_q[g];
    end

    // R12
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr != ADDR_STATUS && addr != ADDR_SENSE_LO && addr != ADDR_SENSE_HI
            && (addr < ADDR_ROUTE0 || addr >= ADDR_ROUTE0 + REG_AW'(4 * ROUTE_REGS)))
        |-> rdata == '0);
endmodule

// File: rtl/gir_slot.sv
module gir_slot
    import gir_pkg::*;
#(
    parameter int SEL_W = 7,
    localparam int POOL = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] src,
    input  logic [1:0]       sense,
    input  logic [POOL-1:0]  pool,
    input  logic             clr,
    output logic             status_q
);
    slot_state_t      state_q, state_d;
    logic [SEL_W-1:0] src_last_q;
    logic             hist_q;
    logic             cur, src_moved, armed, cond, hit, edge_hit;
    sense_t           mode;

    assign mode      = sense_t'(sense);
    assign cur       = pool[src];
    assign src_moved = (src != src_last_q);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_OFF:   if (en) state_d = SLOT_PRIME;
            SLOT_PRIME: state_d = en ? SLOT_LIVE : SLOT_OFF;
            SLOT_LIVE: begin
                if (!en)            state_d = SLOT_OFF;
                else if (src_moved) state_d = SLOT_PRIME;
            end
            default:    state_d = SLOT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_OFF;
        else        state_q <= state_d;
    end

    // output process: detection qualified by state
    always_comb begin
        armed = (state_q == SLOT_LIVE) && en && !src_moved;
        unique case (mode)
            SENSE_RISE: cond = cur & ~hist_q;
            SENSE_FALL: cond = ~cur & hist_q;
            SENSE_HIGH: cond = cur;
            SENSE_LOW:  cond = ~cur;
            default:    cond = 1'b0;
        endcase
        hit      = armed & cond;
        edge_hit = hit & ~sense[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q     <= 1'b0;
            src_last_q <= '0;
            status_q   <= 1'b0;
        end else begin
            hist_q     <= cur;
            src_last_q <= src;
            status_q   <= clr ? edge_hit : (status_q | hit);
        end
    end

    // R10
    set_from_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(state_q) == SLOT_LIVE);

    // R10
    enable_primes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> state_q == SLOT_PRIME);

    // R9
    off_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(status_q));

    // R8
    level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && sense[1]) |=> !status_q);

    // R8
    level_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_LIVE && en && !src_moved && !clr
            && sense == SENSE_HIGH && cur) |=> status_q);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_GPIO  = 128,
    parameter int SEL_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_GPIO-1:0]  gpio_in,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    input  logic                 reg_we,
    input  logic                 reg_re,
    output logic [31:0]          reg_rdata,
    output logic [NUM_SLOTS-1:0] irq_out
);
    localparam int POOL = 1 << SEL_W;

    logic [NUM_GPIO-1:0]        gpio_s;
    logic [POOL-1:0]            pool;
    logic [NUM_SLOTS-1:0]       en, status, clr;
    logic [NUM_SLOTS*SEL_W-1:0] src_flat;
    logic [2*NUM_SLOTS-1:0]     sense_flat;

    gir_sync #(.W(NUM_GPIO)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_s)
    );

    for (genvar p = 0; p < POOL; p++) begin : g_pool
        if (p < NUM_GPIO) begin : g_wired
            assign pool[p] = gpio_s[p];
        end else begin : g_tied
            assign pool[p] = 1'b0;
        end
    end

    gir_regfile #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(reg_addr), .wdata(reg_wdata), .we(reg_we), .re(reg_re),
        .rdata(reg_rdata), .status(status),
        .en(en), .src_flat(src_flat), .sense_flat(sense_flat)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign clr[s] = reg_we && (reg_addr == ADDR_STATUS) && !reg_wdata[s];

        gir_slot #(.SEL_W(SEL_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .en(en[s]),
            .src(src_flat[s*SEL_W +: SEL_W]),
            .sense(sense_flat[2*s +: 2]),
            .pool(pool),
            .clr(clr[s]),
            .status_q(status[s])
        );
    end

    assign irq_out = status & en;
endmodule

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
    localparam int NG = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NG-1:0] gpio = '0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic [31:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_irq_router #(.NUM_GPIO(NG)) uut (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio),
        .reg_addr(addr), .reg_wdata(wdata), .reg_we(we), .reg_re(re),
        .reg_rdata(rdata), .irq_out(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        #1 d = rdata;
        re = 1'b0;
    endtask

    function automatic logic [7:0] route_a(input int n);
        return 8'h30 + 8'(4 * (n / 4));
    endfunction

    function automatic logic [7:0] sense_a(input int n);
        return (n < 16) ? 8'h24 : 8'h28;
    endfunction

    function automatic logic [31:0] route_d(input int n, input bit e, input int s);
        return {24'h0, e, 7'(s)} << (8 * (n % 4));
    endfunction

    function automatic logic [31:0] sense_d(input int n, input int m);
        return 32'(m) << (2 * (n % 16));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: reset values
        chk(irq == 0, "R1 irq", irq, 0);
        rd(8'h20, v); chk(v == 0, "R1 status", v, 0);
        rd(8'h24, v); chk(v == 0, "R1 sense lo", v, 0);
        rd(8'h28, v); chk(v == 0, "R1 sense hi", v, 0);
        for (int k = 0; k < 8; k++) begin
            rd(8'h30 + 8'(4 * k), v); chk(v == 0, "R1 route", v, 0);
        end

        // R2 / R3: readback, R12: unmapped
        wr(8'h24, 32'hE4E4_1B1B); rd(8'h24, v); chk(v == 32'hE4E4_1B1B, "R3 readback lo", v, 32'hE4E4_1B1B);
        wr(8'h28, 32'h1B1B_E4E4); rd(8'h28, v); chk(v == 32'h1B1B_E4E4, "R3 readback hi", v, 32'h1B1B_E4E4);
        wr(8'h3C, 32'h7F01_2345); rd(8'h3C, v); chk(v == 32'h7F01_2345, "R2 readback", v, 32'h7F01_2345);
        wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, v); chk(v == 0, "R12 unmapped read", v, 0);
        rd(8'h24, v); chk(v == 32'hE4E4_1B1B, "R12 no side effect", v, 32'hE4E4_1B1B);
        rd(8'h50, v); chk(v == 0, "R12 past route", v, 0);
        wr(8'h24, 0); wr(8'h28, 0); wr(8'h3C, 0);
        tick(4);
        rd(8'h20, v); chk(v == 0, "R9 no status while disabled", v, 0);

        // sweep all slots, sense mode rotates
        for (int n = 0; n < 32; n++) begin
            int m, s;
            bit init;
            string tag;
            m = n % 4;
            s = (n * 5 + 3) % NG;
            init = (m == 1 || m == 3);
            tag = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
            gpio[s] = init;
            tick(3);
            wr(sense_a(n), sense_d(n, m));
            wr(route_a(n), route_d(n, 1'b1, s));
            tick(4);
            chk(irq == 0, "R10 no event on enable", irq, 0);
            gpio[s] = ~init;
            tick(2);
            chk(irq == 0, {tag, " early"}, irq, 0);
            tick(1);
            chk(irq == (32'h1 << n), {tag, " request"}, irq, 32'h1 << n);
            rd(8'h20, v); chk(v == (32'h1 << n), "R7 status bit", v, 32'h1 << n);
            if (m >= 2) begin
                wr(8'h20, ~(32'h1 << n));
                chk(irq[n] == 1'b0, "R8 clear drops", irq, 0);
                tick(1);
                chk(irq[n] == 1'b1, "R8 reasserts", irq, 32'h1 << n);
            end else begin
                wr(8'h20, 32'hFFFF_FFFF);
                rd(8'h20, v); chk(v == (32'h1 << n), "R7 write one keeps", v, 32'h1 << n);
                wr(8'h20, ~(32'h1 << n));
                rd(8'h20, v); chk(v == 0, "R7 write zero clears", v, 0);
                gpio[s] = init;
                tick(4);
                chk(irq == 0, {tag, " opposite edge ignored"}, irq, 0);
            end
            wr(route_a(n), 0);
            wr(sense_a(n), 0);
            gpio[s] = 1'b0;
            tick(3);
            wr(8'h20, 0);
            chk(irq == 0, "R9 cleanup", irq, 0);
        end

        // R9: disabled slot ignores events, masking of latched bit
        wr(route_a(5), route_d(5, 1'b0, 7));
        tick(3);
        gpio[7] = 1'b1; tick(4); gpio[7] = 1'b0; tick(4);
        rd(8'h20, v); chk(v == 0, "R9 disabled sets nothing", v, 0);
        chk(irq == 0, "R9 disabled request", irq, 0);
        wr(route_a(5), route_d(5, 1'b1, 7));
        tick(4);
        gpio[7] = 1'b1; tick(4);
        chk(irq == 32'h20, "R9 enabled sets", irq, 32'h20);
        wr(route_a(5), route_d(5, 1'b0, 7));
        chk(irq == 0, "R9 masked", irq, 0);
        rd(8'h20, v); chk(v == 32'h20, "R9 status kept", v, 32'h20);
        wr(route_a(5), route_d(5, 1'b1, 7));
        chk(irq == 32'h20, "R9 unmasked", irq, 32'h20);
        wr(route_a(5), 0); gpio[7] = 1'b0; tick(3); wr(8'h20, 0);

        // R10: source change while enabled
        gpio[10] = 1'b0; gpio[11] = 1'b1; tick(3);
        wr(route_a(2), route_d(2, 1'b1, 10));
        tick(4);
        wr(route_a(2), route_d(2, 1'b1, 11));
        tick(5);
        rd(8'h20, v); chk(v == 0, "R10 no event on source change", v, 0);
        gpio[11] = 1'b0; tick(4); gpio[11] = 1'b1; tick(4);
        rd(8'h20, v); chk(v == 32'h4, "R10 detection resumes", v, 32'h4);
        wr(route_a(2), 0); gpio[11] = 1'b0; tick(3); wr(8'h20, 0);

        // R11: unconnected source numbers read 0
        wr(sense_a(9), sense_d(9, 3));
        wr(route_a(9), route_d(9, 1'b1, 100));
        tick(5);
        rd(8'h20, v); chk(v == 32'h200, "R11 low on unconnected", v, 32'h200);
        wr(route_a(9), 0); tick(1); wr(8'h20, 0);
        wr(sense_a(9), sense_d(9, 2));
        wr(route_a(9), route_d(9, 1'b1, 127));
        gpio = '1;
        tick(6);
        rd(8'h20, v); chk(v == 0, "R11 high never on unconnected", v, 0);
        wr(route_a(9), 0); wr(sense_a(9), 0); gpio = '0; tick(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule